// File: doc/BRIEF.md
# Configurable Serial Shifter Unit

This block is a single programmable shift engine. It sits next to an external timer and moves words between a parallel buffer and one serial line. In transmit mode the buffered word is moved into a shift register and sent out least significant bit first. In receive mode bits enter at the top of the shift register, and the assembled word is stored into the buffer. The external timer supplies a shift clock and a load/store strobe. The shift clock is sampled by the block clock, and either its rising or its falling edge advances the shifter.

Static configuration inputs select the operating mode and optional framing. Framing can add a start bit before the data, a stop bit at the store strobe, or both. On receive, the block checks the framing bits and raises an error flag on a mismatch. It also raises the error flag on buffer overrun. The serial input comes either from the pin or from a neighbouring shifter. The output side drives the pin data and the output enable as the pin-drive field selects, with an optional inversion. The buffer can be read in four bit and byte orders at the same time.

Top module: `ser_shift_unit`

## Requirements
- R1: Mode codes 1 (receive) and 2 (transmit) are active. Any other code, including 4 and 5, is disabled. While disabled, strobes and shift edges have no effect, the status flag reads 0, and `pin_out` and `pin_oe` read 0.
- R2: With `cfg_sclk_fall`=0 a rising edge of `shift_clk` advances the shifter. With `cfg_sclk_fall`=1 only a falling edge does.
- R3: Transmit with start code 0 loads the buffer into the shifter on entry to transmit mode and on every `ld_st` strobe. Each load drives bit 0 at once and sets the status flag. Each following shift edge outputs the next higher bit. A buffer write in transmit mode clears the status flag.
- R4: Transmit with start code 1 defers the load to the first shift edge. Until that edge the status flag stays 0 and the data output keeps its previous level.
- R5: Transmit with start code 2 or 3 drives a start bit of value 0 or 1 at entry or at the strobe. The data is loaded, and the status flag set, on the next shift edge.
- R6: Transmit with stop code 2 or 3 drives a stop bit of 0 or 1 at the `ld_st` strobe. If a start bit is also configured, it follows on the next shift edge. The data is loaded on the shift edge after that.
- R7: Receive shifts the serial input into bit DW-1 and moves the register right on each shift edge. `ld_st` copies the register to the buffer and sets the status flag. A `buf_rd` pulse in receive mode clears the status flag.
- R8: Receive with start code 2 or 3 treats the first shift edge after entry or after a strobe as a start bit. That bit is not stored. The error flag is set if the bit differs from the low bit of the start code.
- R9: Receive with stop code 2 or 3 samples the serial input at the `ld_st` strobe. The error flag is set if the sample differs from the low bit of the stop code.
- R10: A receive store while the status flag is still 1 sets the error flag and still updates the buffer.
- R11: The error flag clears on an `err_clr` pulse, provided no error event happens in the same cycle.
- R12: With `cfg_chain_src`=1 the serial input is `chain_in`. Otherwise it is `pin_in`, inverted when `cfg_pin_inv`=1.
- R13: The pin-drive code sets the outputs from the data bit d, where d is the transmit bit XOR `cfg_pin_inv`. Code 0 gives out=0, oe=0. Code 1 gives out=0, oe=d. Code 2 gives out=d, oe=0. Code 3 gives out=d, oe=1.
- R14: `buf_bitrev` is the buffer with all bits reversed. `buf_byterev` reverses the byte order. `buf_bbrev` reverses the bits inside each byte and keeps the bytes in place.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_mode | input | 3 | Operating mode code |
| cfg_sclk_fall | input | 1 | 1: shift on falling edge of shift_clk |
| cfg_pin_cfg | input | 2 | Pin-drive code |
| cfg_pin_inv | input | 1 | Pin active low (inverts pin data both ways) |
| cfg_start | input | 2 | Start framing / load timing code |
| cfg_stop | input | 2 | Stop framing code |
| cfg_chain_src | input | 1 | 1: serial input from neighbour shifter |
| shift_clk | input | 1 | Shift clock from the timer |
| ld_st | input | 1 | Load/store strobe from the timer |
| pin_in | input | 1 | Serial input from the pin |
| chain_in | input | 1 | Serial input from the neighbour shifter |
| buf_wr | input | 1 | Buffer write strobe |
| buf_wdata | input | DW | Buffer write data |
| buf_rd | input | 1 | Buffer read strobe |
| err_clr | input | 1 | Write-one-to-clear for the error flag |
| pin_out | output | 1 | Pin output data |
| pin_oe | output | 1 | Pin output enable |
| chain_out | output | 1 | Serial data towards the neighbour shifter |
| status | output | 1 | Buffer status flag |
| error | output | 1 | Framing/overrun error flag |
| buf_raw | output | DW | Buffer, unchanged order |
| buf_bitrev | output | DW | Buffer, all bits reversed |
| buf_byterev | output | DW | Buffer, bytes reversed |
| buf_bbrev | output | DW | Buffer, bits reversed inside each byte |

## Verification
The bench builds the unit with its default width of 32 bits and 8-bit lanes, so the buffer holds four distinct bytes. With four bytes, every byte-order view moves each byte to a different lane, and a wrong lane mapping cannot give the right value. The 32-bit receive words put the first received bit into bit 0 only after a full word of shifts, which exposes any off-by-one error in the shift path. Narrower builds are not exercised.

// File: rtl/shu_pkg.sv
`timescale 1ns/1ps
package shu_pkg;

  typedef enum logic [1:0] {
    OP_OFF = 2'd0,
    OP_RX  = 2'd1,
    OP_TX  = 2'd2
  } op_e;

  typedef enum logic [1:0] {
    DRV_NONE = 2'd0,
    DRV_OE   = 2'd1,
    DRV_DATA = 2'd2,
    DRV_FULL = 2'd3
  } drv_e;

  localparam logic [2:0] MODE_CODE_RX = 3'd1;
  localparam logic [2:0] MODE_CODE_TX = 3'd2;
  localparam logic [1:0] START_LOAD_ON_SHIFT = 2'd1;

  function automatic op_e decode_mode(input logic [2:0] code);
    op_e r;
    case (code)
      MODE_CODE_RX: r = OP_RX;
      MODE_CODE_TX: r = OP_TX;
      default:      r = OP_OFF;
    endcase
    return r;
  endfunction

endpackage

// File: rtl/shu_edge.sv
`timescale 1ns/1ps
module shu_edge (
  input  logic clk,
  input  logic rst,
  input  logic sclk,
  input  logic fall_sel,
  output logic shift_ev
);
  logic sclk_q;

  always_ff @(posedge clk) begin
    if (rst) sclk_q <= 1'b0;
    else     sclk_q <= sclk;
  end

  always_comb begin
    if (fall_sel) shift_ev = sclk_q & ~sclk;
    else          shift_ev = sclk & ~sclk_q;
  end
endmodule

// File: rtl/shu_view.sv
`timescale 1ns/1ps
module shu_view #(
  parameter int DW     = 32,
  parameter int BYTE_W = 8
) (
  input  logic [DW-1:0] word,
  output logic [DW-1:0] bitrev,
  output logic [DW-1:0] byterev,
  output logic [DW-1:0] bbrev
);
  localparam int NBYTES = DW / BYTE_W;

  for (genvar i = 0; i < DW; i++) begin : g_bit
    assign bitrev[i] = word[DW-1-i];
  end

  for (genvar b = 0; b < NBYTES; b++) begin : g_lane
    for (genvar i = 0; i < BYTE_W; i++) begin : g_pos
      assign byterev[b*BYTE_W+i] = word[(NBYTES-1-b)*BYTE_W+i];
      assign bbrev[b*BYTE_W+i]   = word[b*BYTE_W+BYTE_W-1-i];
    end
  end
endmodule

// File: rtl/shu_pin_drive.sv
`timescale 1ns/1ps
module shu_pin_drive
  import shu_pkg::*;
(
  input  logic       active,
  input  logic [1:0] drv_code,
  input  logic       invert,
  input  logic       data,
  output logic       out,
  output logic       oe
);
  logic d;

  always_comb begin
    d   = data ^ invert;
    out = 1'b0;
    oe  = 1'b0;
    if (active) begin
      case (drv_e'(drv_code))
        DRV_OE:   oe = d;
        DRV_DATA: out = d;
        DRV_FULL: begin out = d; oe = 1'b1; end
        default:  ;
      endcase
    end
  end
endmodule

// File: rtl/ser_shift_unit.sv
`timescale 1ns/1ps
module ser_shift_unit
  import shu_pkg::*;
#(
  parameter int DW     = 32,
  parameter int BYTE_W = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [2:0]    cfg_mode,
  input  logic          cfg_sclk_fall,
  input  logic [1:0]    cfg_pin_cfg,
  input  logic          cfg_pin_inv,
  input  logic [1:0]    cfg_start,
  input  logic [1:0]    cfg_stop,
  input  logic          cfg_chain_src,
  input  logic          shift_clk,
  input  logic          ld_st,
  input  logic          pin_in,
  input  logic          chain_in,
  input  logic          buf_wr,
  input  logic [DW-1:0] buf_wdata,
  input  logic          buf_rd,
  input  logic          err_clr,
  output logic          pin_out,
  output logic          pin_oe,
  output logic          chain_out,
  output logic          status,
  output logic          error,
  output logic [DW-1:0] buf_raw,
  output logic [DW-1:0] buf_bitrev,
  output logic [DW-1:0] buf_byterev,
  output logic [DW-1:0] buf_bbrev
);

  op_e           op, op_q;
  logic          enter;
  logic          shift_ev;
  logic          in_bit;
  logic          frame_start, start_val, stop_en, stop_val, defer_load;

  logic [DW-1:0] sr_q, sr_d;
  logic [DW-1:0] buf_q, buf_d;
  logic          txd_q, txd_d;
  logic          pend_start_q, pend_start_d;
  logic          pend_load_q, pend_load_d;
  logic          status_q, status_d;
  logic          error_q, error_d;
  logic          err_set;

  shu_edge u_edge (
    .clk      (clk),
    .rst      (rst),
    .sclk     (shift_clk),
    .fall_sel (cfg_sclk_fall),
    .shift_ev (shift_ev)
  );

  always_comb begin
    op          = decode_mode(cfg_mode);
    enter       = (op != op_q);
    in_bit      = cfg_chain_src ? chain_in : (pin_in ^ cfg_pin_inv);
    frame_start = cfg_start[1];
    start_val   = cfg_start[0];
    stop_en     = cfg_stop[1];
    stop_val    = cfg_stop[0];
    defer_load  = (cfg_start == START_LOAD_ON_SHIFT);
  end

  // next-state of the shift engine
  always_comb begin
    sr_d         = sr_q;
    buf_d        = buf_q;
    txd_d        = txd_q;
    pend_start_d = pend_start_q;
    pend_load_d  = pend_load_q;
    status_d     = status_q;
    err_set      = 1'b0;

    if (buf_wr) begin
      buf_d = buf_wdata;
      if (op == OP_TX) status_d = 1'b0;
    end
    if (buf_rd && op == OP_RX) status_d = 1'b0;

    case (op)
      OP_TX: begin
        if (enter) begin
          pend_start_d = 1'b0;
          if (frame_start) begin
            txd_d       = start_val;
            pend_load_d = 1'b1;
          end else if (defer_load) begin
            pend_load_d = 1'b1;
          end else begin
            txd_d       = buf_q[0];
            sr_d        = {1'b0, buf_q[DW-1:1]};
            status_d    = 1'b1;
            pend_load_d = 1'b0;
          end
        end else if (ld_st) begin
          if (stop_en) begin
            txd_d        = stop_val;
            pend_start_d = frame_start;
            pend_load_d  = 1'b1;
          end else if (frame_start) begin
            txd_d       = start_val;
            pend_load_d = 1'b1;
          end else if (defer_load) begin
            pend_load_d = 1'b1;
          end else begin
            txd_d       = buf_q[0];
            sr_d        = {1'b0, buf_q[DW-1:1]};
            status_d    = 1'b1;
            pend_load_d = 1'b0;
          end
        end else if (shift_ev) begin
          if (pend_start_q) begin
            txd_d        = start_val;
            pend_start_d = 1'b0;
          end else if (pend_load_q) begin
            txd_d       = buf_q[0];
            sr_d        = {1'b0, buf_q[DW-1:1]};
            status_d    = 1'b1;
            pend_load_d = 1'b0;
          end else begin
            txd_d = sr_q[0];
            sr_d  = {1'b0, sr_q[DW-1:1]};
          end
        end
      end
      OP_RX: begin
        pend_load_d = 1'b0;
        if (enter) begin
          pend_start_d = frame_start;
          status_d     = 1'b0;
        end else if (ld_st) begin
          buf_d        = sr_q;
          status_d     = 1'b1;
          err_set      = status_q || (stop_en && (in_bit != stop_val));
          pend_start_d = frame_start;
        end else if (shift_ev) begin
          if (pend_start_q) begin
            pend_start_d = 1'b0;
            err_set      = (in_bit != start_val);
          end else begin
            sr_d = {in_bit, sr_q[DW-1:1]};
          end
        end
      end
      default: begin
        status_d     = 1'b0;
        pend_start_d = 1'b0;
        pend_load_d  = 1'b0;
      end
    endcase

    error_d = (error_q & ~err_clr) | err_set;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      op_q         <= OP_OFF;
      sr_q         <= '0;
      buf_q        <= '0;
      txd_q        <= 1'b0;
      pend_start_q <= 1'b0;
      pend_load_q  <= 1'b0;
      status_q     <= 1'b0;
      error_q      <= 1'b0;
    end else begin
      op_q         <= op;
      sr_q         <= sr_d;
      buf_q        <= buf_d;
      txd_q        <= txd_d;
      pend_start_q <= pend_start_d;
      pend_load_q  <= pend_load_d;
      status_q     <= status_d;
      error_q      <= error_d;
    end
  end

  shu_pin_drive u_drive (
    .active   (op_q != OP_OFF),
    .drv_code (cfg_pin_cfg),
    .invert   (cfg_pin_inv),
    .data     (txd_q),
    .out      (pin_out),
    .oe       (pin_oe)
  );

  shu_view #(.DW(DW), .BYTE_W(BYTE_W)) u_view (
    .word    (buf_q),
    .bitrev  (buf_bitrev),
    .byterev (buf_byterev),
    .bbrev   (buf_bbrev)
  );

  assign chain_out = txd_q;
  assign status    = status_q;
  assign error     = error_q;
  assign buf_raw   = buf_q;

endmodule

// File: rtl/shu_checker.sv
`timescale 1ns/1ps
module shu_checker #(
  parameter int DW = 32
) (
  input logic          clk,
  input logic          rst,
  input logic [2:0]    cfg_mode,
  input logic [1:0]    cfg_pin_cfg,
  input logic          ld_st,
  input logic          shift_ev,
  input logic          err_clr,
  input logic          status,
  input logic          error,
  input logic          pin_oe,
  input logic [DW-1:0] buf_raw,
  input logic [DW-1:0] buf_bitrev,
  input logic [DW-1:0] buf_byterev
);
  logic is_off, is_rx;
  assign is_rx  = (cfg_mode == 3'd1);
  assign is_off = !(cfg_mode == 3'd1 || cfg_mode == 3'd2);

  assert_off_quiet_R1: assert property (@(posedge clk) disable iff (rst)
    (is_off && $past(is_off)) |-> (!status && !pin_oe));

  assert_rx_status_source_R7: assert property (@(posedge clk) disable iff (rst)
    (is_rx && $past(is_rx) && $rose(status)) |-> $past(ld_st));

  // R8 R9 R10: errors come only from a strobe or a shift edge
  assert_err_cause_R9: assert property (@(posedge clk) disable iff (rst)
    $rose(error) |-> $past(ld_st || shift_ev));

  assert_err_clear_R11: assert property (@(posedge clk) disable iff (rst)
    ($past(err_clr) && !$past(ld_st) && !$past(shift_ev)) |-> !error);

  assert_full_drive_R13: assert property (@(posedge clk) disable iff (rst)
    (!is_off && $past(!is_off) && cfg_pin_cfg == 2'd3) |-> pin_oe);

  assert_view_order_R14: assert property (@(posedge clk) disable iff (rst)
    (buf_bitrev[0] == buf_raw[DW-1]) && (buf_byterev[7:0] == buf_raw[DW-1 -: 8]));
endmodule

bind ser_shift_unit shu_checker #(.DW(DW)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .cfg_mode    (cfg_mode),
  .cfg_pin_cfg (cfg_pin_cfg),
  .ld_st       (ld_st),
  .shift_ev    (shift_ev),
  .err_clr     (err_clr),
  .status      (status),
  .error       (error),
  .pin_oe      (pin_oe),
  .buf_raw     (buf_raw),
  .buf_bitrev  (buf_bitrev),
  .buf_byterev (buf_byterev)
);

// File: tb/test_ser_shift_unit.sv
`timescale 1ns/1ps
module test_ser_shift_unit;
  localparam int DW = 32;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [2:0] cfg_mode = 3'd0;
  logic cfg_sclk_fall = 1'b0;
  logic [1:0] cfg_pin_cfg = 2'd0;
  logic cfg_pin_inv = 1'b0;
  logic [1:0] cfg_start = 2'd0;
  logic [1:0] cfg_stop = 2'd0;
  logic cfg_chain_src = 1'b0;
  logic shift_clk = 1'b0, ld_st = 1'b0, pin_in = 1'b0, chain_in = 1'b0;
  logic buf_wr = 1'b0, buf_rd = 1'b0, err_clr = 1'b0;
  logic [DW-1:0] buf_wdata = '0;
  logic pin_out, pin_oe, chain_out, status, error;
  logic [DW-1:0] buf_raw, buf_bitrev, buf_byterev, buf_bbrev;

  int checks = 0;
  int failures = 0;

  always #2.5 clk = ~clk;

  ser_shift_unit #(.DW(DW)) i_ser_shift_unit (
    .clk(clk), .rst(rst), .cfg_mode(cfg_mode), .cfg_sclk_fall(cfg_sclk_fall),
    .cfg_pin_cfg(cfg_pin_cfg), .cfg_pin_inv(cfg_pin_inv), .cfg_start(cfg_start),
    .cfg_stop(cfg_stop), .cfg_chain_src(cfg_chain_src), .shift_clk(shift_clk),
    .ld_st(ld_st), .pin_in(pin_in), .chain_in(chain_in), .buf_wr(buf_wr),
    .buf_wdata(buf_wdata), .buf_rd(buf_rd), .err_clr(err_clr), .pin_out(pin_out),
    .pin_oe(pin_oe), .chain_out(chain_out), .status(status), .error(error),
    .buf_raw(buf_raw), .buf_bitrev(buf_bitrev), .buf_byterev(buf_byterev),
    .buf_bbrev(buf_bbrev)
  );

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  task automatic set_cfg(input logic [2:0] m, input logic fall, input logic [1:0] pc,
                         input logic inv, input logic [1:0] st, input logic [1:0] sp,
                         input logic chain);
    @(negedge clk);
    cfg_mode = m; cfg_sclk_fall = fall; cfg_pin_cfg = pc; cfg_pin_inv = inv;
    cfg_start = st; cfg_stop = sp; cfg_chain_src = chain;
    @(negedge clk);
  endtask

  task automatic write_buf(input logic [DW-1:0] w);
    @(negedge clk); buf_wr = 1'b1; buf_wdata = w;
    @(negedge clk); buf_wr = 1'b0;
  endtask

  task automatic read_buf();
    @(negedge clk); buf_rd = 1'b1;
    @(negedge clk); buf_rd = 1'b0;
  endtask

  task automatic strobe();
    @(negedge clk); ld_st = 1'b1;
    @(negedge clk); ld_st = 1'b0;
  endtask

  task automatic clr_err();
    @(negedge clk); err_clr = 1'b1;
    @(negedge clk); err_clr = 1'b0;
  endtask

  task automatic sclk_pulse();
    @(negedge clk); shift_clk = 1'b1;
    @(negedge clk); shift_clk = 1'b0;
    @(negedge clk);
  endtask

  // src: 0 pin, 1 chain (pin opposite), 2 inverted pin
  task automatic rx_bit(input logic b, input int src);
    chain_in = (src == 1) ? b : ~b;
    pin_in   = (src == 0) ? b : ~b;
    sclk_pulse();
  endtask

  task automatic rx_word(input logic [DW-1:0] w, input int src);
    for (int i = 0; i < DW; i++) rx_bit(w[i], src);
  endtask

  task automatic t_reset();
    chk("R1", "reset status", status, 0);
    chk("R11", "reset error", error, 0);
    chk("R1", "reset oe", pin_oe, 0);
    chk("R14", "reset buffer", buf_raw, 0);
  endtask

  task automatic t_views();
    write_buf(32'h1234_5678);
    chk("R14", "raw", buf_raw, 32'h1234_5678);
    chk("R14", "bitrev", buf_bitrev, 32'h1E6A_2C48);
    chk("R14", "byterev", buf_byterev, 32'h7856_3412);
    chk("R14", "bbrev", buf_bbrev, 32'h482C_6A1E);
  endtask

  task automatic t_off();
    set_cfg(3'd4, 0, 2'd3, 0, 2'd0, 2'd0, 0);
    chk("R1", "mode4 oe", pin_oe, 0);
    strobe();
    sclk_pulse();
    chk("R1", "mode4 status", status, 0);
    set_cfg(3'd5, 0, 2'd3, 0, 2'd0, 2'd0, 0);
    strobe();
    chk("R1", "mode5 status", status, 0);
    chk("R1", "mode5 oe", pin_oe, 0);
    chk("R1", "mode5 out", pin_out, 0);
  endtask

  task automatic t_tx_basic();
    logic [DW-1:0] w = 32'hA5C3_0F96;
    set_cfg(3'd0, 0, 2'd3, 0, 2'd0, 2'd0, 0);
    write_buf(w);
    set_cfg(3'd2, 0, 2'd3, 0, 2'd0, 2'd0, 0);
    chk("R3", "status after enable load", status, 1);
    chk("R3", "bit0", pin_out, w[0]);
    chk("R13", "full drive oe", pin_oe, 1);
    for (int k = 1; k < 8; k++) begin
      sclk_pulse();
      chk("R3", $sformatf("bit%0d", k), pin_out, w[k]);
    end
    write_buf(32'h0000_0001);
    chk("R3", "write clears status", status, 0);
    strobe();
    chk("R3", "strobe load status", status, 1);
    chk("R3", "strobe load bit0", pin_out, 1);
  endtask

  task automatic t_pin();
    @(negedge clk); cfg_pin_cfg = 2'd0;
    @(negedge clk);
    chk("R13", "code0 out", pin_out, 0); chk("R13", "code0 oe", pin_oe, 0);
    cfg_pin_cfg = 2'd1;
    @(negedge clk);
    chk("R13", "code1 out", pin_out, 0); chk("R13", "code1 oe", pin_oe, 1);
    cfg_pin_cfg = 2'd2;
    @(negedge clk);
    chk("R13", "code2 out", pin_out, 1); chk("R13", "code2 oe", pin_oe, 0);
    cfg_pin_cfg = 2'd3; cfg_pin_inv = 1'b1;
    @(negedge clk);
    chk("R13", "code3 inv out", pin_out, 0); chk("R13", "code3 inv oe", pin_oe, 1);
    cfg_pin_inv = 1'b0;
  endtask

  task automatic t_edge();
    set_cfg(3'd0, 1, 2'd3, 0, 2'd0, 2'd0, 0);
    write_buf(32'h0000_0002);
    set_cfg(3'd2, 1, 2'd3, 0, 2'd0, 2'd0, 0);
    chk("R2", "bit0", pin_out, 0);
    @(negedge clk); shift_clk = 1'b1;
    @(negedge clk);
    chk("R2", "no shift on rise", pin_out, 0);
    shift_clk = 1'b0;
    @(negedge clk);
    chk("R2", "shift on fall", pin_out, 1);
  endtask

  task automatic t_tx_deferred();
    set_cfg(3'd0, 0, 2'd3, 0, 2'd0, 2'd0, 0);
    write_buf(32'h0000_0006);
    set_cfg(3'd2, 0, 2'd3, 0, 2'd1, 2'd0, 0);
    chk("R4", "no load at enable status", status, 0);
    chk("R4", "level held", pin_out, 1);
    sclk_pulse();
    chk("R4", "load on first shift", pin_out, 0);
    chk("R4", "status after load", status, 1);
    sclk_pulse();
    chk("R4", "bit1", pin_out, 1);
  endtask

  task automatic t_tx_start();
    set_cfg(3'd0, 0, 2'd3, 0, 2'd0, 2'd0, 0);
    write_buf(32'h0000_00FF);
    set_cfg(3'd2, 0, 2'd3, 0, 2'd2, 2'd0, 0);
    chk("R5", "start bit 0", pin_out, 0);
    chk("R5", "status before load", status, 0);
    sclk_pulse();
    chk("R5", "data bit0", pin_out, 1);
    chk("R5", "status after load", status, 1);
    set_cfg(3'd0, 0, 2'd3, 0, 2'd0, 2'd0, 0);
    write_buf(32'h0000_0000);
    set_cfg(3'd2, 0, 2'd3, 0, 2'd3, 2'd0, 0);
    chk("R5", "start bit 1", pin_out, 1);
    sclk_pulse();
    chk("R5", "data bit0 after start 1", pin_out, 0);
  endtask

  task automatic t_tx_stop();
    set_cfg(3'd2, 0, 2'd3, 0, 2'd0, 2'd3, 0);
    write_buf(32'h0000_0004);
    strobe();
    chk("R6", "stop bit 1", pin_out, 1);
    chk("R6", "status during stop", status, 0);
    sclk_pulse();
    chk("R6", "data bit0 after stop", pin_out, 0);
    chk("R6", "status after load", status, 1);
    sclk_pulse(); sclk_pulse();
    chk("R6", "data bit2", pin_out, 1);
    write_buf(32'h0000_0001);
    set_cfg(3'd2, 0, 2'd3, 0, 2'd2, 2'd3, 0);
    strobe();
    chk("R6", "stop before start", pin_out, 1);
    sclk_pulse();
    chk("R6", "start after stop", pin_out, 0);
    chk("R6", "not yet loaded", status, 0);
    sclk_pulse();
    chk("R6", "data after start", pin_out, 1);
    chk("R6", "loaded", status, 1);
  endtask

  task automatic t_rx();
    set_cfg(3'd0, 0, 2'd0, 0, 2'd0, 2'd0, 0);
    set_cfg(3'd1, 0, 2'd0, 0, 2'd0, 2'd0, 0);
    chk("R7", "status on entry", status, 0);
    rx_word(32'hDEAD_BEEF, 0);
    strobe();
    chk("R7", "status after store", status, 1);
    chk("R7", "stored word", buf_raw, 32'hDEAD_BEEF);
    chk("R7", "no error", error, 0);
    read_buf();
    chk("R7", "read clears status", status, 0);
  endtask

  task automatic t_overrun();
    rx_word(32'h1357_9BDF, 0);
    strobe();
    chk("R10", "first store no error", error, 0);
    rx_word(32'h2468_ACE0, 0);
    strobe();
    chk("R10", "overrun error", error, 1);
    chk("R10", "buffer updated", buf_raw, 32'h2468_ACE0);
    clr_err();
    chk("R11", "w1c clears", error, 0);
    chk("R11", "status untouched", status, 1);
    read_buf();
  endtask

  task automatic t_frame();
    set_cfg(3'd0, 0, 2'd0, 0, 2'd0, 2'd0, 0);
    set_cfg(3'd1, 0, 2'd0, 0, 2'd2, 2'd3, 0);
    rx_bit(1'b1, 0);
    chk("R8", "bad start bit", error, 1);
    clr_err();
    chk("R11", "clear after start error", error, 0);
    rx_word(32'h0F0F_1234, 0);
    pin_in = 1'b1;
    strobe();
    chk("R9", "good stop no error", error, 0);
    chk("R8", "start bit not stored", buf_raw, 32'h0F0F_1234);
    read_buf();
    rx_bit(1'b0, 0);
    chk("R8", "good start no error", error, 0);
    rx_word(32'hCAFE_0001, 0);
    pin_in = 1'b0;
    strobe();
    chk("R9", "bad stop error", error, 1);
    chk("R9", "word stored", buf_raw, 32'hCAFE_0001);
    clr_err();
    read_buf();
  endtask

  task automatic t_src();
    set_cfg(3'd0, 0, 2'd0, 0, 2'd0, 2'd0, 0);
    set_cfg(3'd1, 0, 2'd0, 0, 2'd0, 2'd0, 1);
    rx_word(32'h89AB_CDEF, 1);
    strobe();
    chk("R12", "chain source", buf_raw, 32'h89AB_CDEF);
    read_buf();
    set_cfg(3'd1, 0, 2'd0, 1, 2'd0, 2'd0, 0);
    rx_word(32'h0123_ABCD, 2);
    strobe();
    chk("R12", "inverted pin source", buf_raw, 32'h0123_ABCD);
    chk("R12", "no error", error, 0);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_views();
    t_off();
    t_tx_basic();
    t_pin();
    t_edge();
    t_tx_deferred();
    t_tx_start();
    t_tx_stop();
    t_rx();
    t_overrun();
    t_frame();
    t_src();
    summary();
  end

  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=timeout expected=completion");
    summary();
  end
endmodule